// File: doc/BRIEF.md
# Remote Terminal Command Decode and Status Capture

This block sits behind the word validator of a dual-redundant serial bus remote terminal. It takes each command word that has already passed coding and parity checks and decides whether the terminal must act on it. A command is accepted when its address field equals the terminal's own address, or equals the broadcast address while broadcast is enabled. An accepted command is split into direction, subaddress and word-count fields. The block marks subaddresses 0 and 31 as mode commands and holds an active-low in-command indicator until the message sequencer reports that servicing has ended.

While the command is being serviced, the block gives the subsystem a fixed decode window. It then samples the subsystem's busy and service-request lines, the externally decoded illegal-command line, and the three flag inputs, all on one fixed clock edge. From the captured values it builds the status word. A captured busy raises a transfer-inhibit output that stops ordinary data-word traffic with the subsystem. The two data-carrying mode commands, synchronize-with-data and transmit-vector, still proceed.

Top module: `rt_cmd_status`

## Requirements
- R1: A command strobe is accepted only when bits 15:11 of the command word equal `term_addr`, or equal 31 while `bcast_en` is 1. `addr_match` shows the result of the most recent strobe. A strobe that is not accepted leaves `in_cmd_n`, the field outputs and the status word unchanged.
- R2: From the cycle after an accepted strobe, the field outputs are as follows. `cmd_tx` is bit 10 (1 = transmit). `cmd_sa` is bits 9:5. `cmd_wc` is bits 4:0.
- R3: `in_cmd_n` goes low in the cycle after an accepted strobe and returns high in the cycle after `cmd_done`. While it is low, the field outputs hold until another command is accepted.
- R4: `mode_cmd` is 1 exactly when the accepted subaddress is 0 or 31.
- R5: Busy and service request are sampled on the second rising clock edge after the edge that accepted the command. Their values on other edges are ignored. All captured status bits clear on acceptance.
- R6: `xfer_inhibit` is 1 while `in_cmd_n` is low and busy was captured, unless the command is one of two exempt mode commands. The exempt commands are subaddress 0 or 31 with `cmd_tx`=0 and mode code 10001 (synchronize with data), and subaddress 0 or 31 with `cmd_tx`=1 and mode code 10000 (transmit vector).
- R7: A captured service request sets only status bit 8 and has no effect on `xfer_inhibit`.
- R8: On the same sample edge, the block captures the illegal-command input into status bit 10, the terminal flag into bit 0, the subsystem flag into bit 2, and dynamic bus control acceptance into bit 1.
- R9: The status word is laid out as follows. Bits 15:11 hold the accepted terminal address. Bit 4 is broadcast received, set when the command was accepted through address 31. Bit 3 is busy. Bits 9 and 7:5 are 0.
- R10: After reset, `in_cmd_n` is 1 and every other output is 0.
- R11: If `cmd_done` arrives before the sample edge, nothing is captured. A new accepted command during servicing restarts decoding and sampling, and the new command takes priority over a sample edge that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: validated command word present |
| cmd_word | input | 16 | Validated command word |
| term_addr | input | 5 | This terminal's address |
| bcast_en | input | 1 | Enables acceptance of address 31 |
| cmd_done | input | 1 | One-cycle strobe: servicing of the current command ended |
| sub_busy | input | 1 | Subsystem busy |
| sub_srq | input | 1 | Subsystem service request |
| sub_illegal | input | 1 | Externally decoded illegal command |
| sub_tflag | input | 1 | Terminal flag request |
| sub_sflag | input | 1 | Subsystem flag |
| sub_dbca | input | 1 | Dynamic bus control acceptance |
| addr_match | output | 1 | Result of the last address comparison |
| cmd_sa | output | 5 | Subaddress / mode field |
| cmd_tx | output | 1 | Direction, 1 = transmit |
| cmd_wc | output | 5 | Word count / mode code |
| in_cmd_n | output | 1 | Low while a command is serviced |
| mode_cmd | output | 1 | Subaddress is 0 or 31 |
| status_word | output | 16 | Assembled status word |
| xfer_inhibit | output | 1 | Blocks ordinary data transfers |

## Verification
The assertions check the following on every cycle: acceptance always pulls in-command low, the fields stay still while a command is serviced, a rejected strobe leaves in-command alone, captured bits clear on acceptance and rise only from a pending sample, and the exempt mode commands never raise the inhibit. Several behaviours appear only in the bench's scenarios. These are the exact sample edge, with busy held one edge early or late; the status word values for each input mix; broadcast handling with the enable on and off; cancellation by an early done; and a restarting command overriding a sample edge.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam logic [4:0] MODE_SYNC_DATA = 5'b10001;
  localparam logic [4:0] MODE_TX_VECTOR = 5'b10000;
  localparam int ST_MERR = 10;
  localparam int ST_SRQ  = 8;
  localparam int ST_BCR  = 4;
  localparam int ST_BUSY = 3;
  localparam int ST_SSF  = 2;
  localparam int ST_DBCA = 1;
  localparam int ST_TF   = 0;
endpackage

// File: rtl/rtcs_decode.sv
module rtcs_decode #(
  parameter int ADDR_W = 5,
  parameter int SA_W   = 5,
  parameter int WC_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [ADDR_W+SA_W+WC_W:0] cmd_word,
  input  logic [ADDR_W-1:0]    term_addr,
  input  logic                 bcast_en,
  input  logic                 cmd_done,
  output logic                 accept,
  output logic                 addr_match,
  output logic [SA_W-1:0]      sa_q,
  output logic                 tx_q,
  output logic [WC_W-1:0]      wc_q,
  output logic                 in_cmd_n,
  output logic                 mode_q,
  output logic                 bcr_q,
  output logic                 exempt_q,
  output logic [ADDR_W-1:0]    addr_q
);
  import rtcs_pkg::*;
  localparam int SA_LO   = WC_W;
  localparam int DIR_POS = WC_W + SA_W;
  localparam int ADDR_LO = DIR_POS + 1;
  localparam logic [ADDR_W-1:0] BCAST = '1;
  localparam logic [SA_W-1:0]   SA_MODE_HI = '1;

  logic [ADDR_W-1:0] f_addr;
  logic [SA_W-1:0]   f_sa;
  logic [WC_W-1:0]   f_wc;
  logic              f_tx, match, is_bc, is_mode, is_exempt;

  always_comb begin
    f_addr    = cmd_word[ADDR_LO +: ADDR_W];
    f_sa      = cmd_word[SA_LO +: SA_W];
    f_wc      = cmd_word[0 +: WC_W];
    f_tx      = cmd_word[DIR_POS];
    is_bc     = bcast_en && (f_addr == BCAST);
    match     = (f_addr == term_addr) || is_bc;
    accept    = cmd_valid && match;
    is_mode   = (f_sa == '0) || (f_sa == SA_MODE_HI);
    is_exempt = is_mode && ((!f_tx && f_wc == WC_W'(MODE_SYNC_DATA)) ||
                            ( f_tx && f_wc == WC_W'(MODE_TX_VECTOR)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_match <= 1'b0;
      sa_q       <= '0;
      tx_q       <= 1'b0;
      wc_q       <= '0;
      in_cmd_n   <= 1'b1;
      mode_q     <= 1'b0;
      bcr_q      <= 1'b0;
      exempt_q   <= 1'b0;
      addr_q     <= '0;
    end else begin
      if (cmd_valid) addr_match <= match;
      if (accept) begin
        sa_q     <= f_sa;
        tx_q     <= f_tx;
        wc_q     <= f_wc;
        in_cmd_n <= 1'b0;
        mode_q   <= is_mode;
        bcr_q    <= is_bc && (f_addr != term_addr);
        exempt_q <= is_exempt;
        addr_q   <= term_addr;
      end else if (cmd_done) begin
        in_cmd_n <= 1'b1;
      end
    end
  end

  assert_enter_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_cmd_n);
  assert_fields_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_cmd_n && !accept) |=> ($stable(sa_q) && $stable(tx_q) && $stable(wc_q)));
  assert_reject_no_effect_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !accept && !cmd_done) |=> $stable(in_cmd_n));
endmodule

// File: rtl/rtcs_sample.sv
module rtcs_sample #(
  parameter int SAMPLE_EDGE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic cmd_done,
  input  logic busy_i,
  input  logic srq_i,
  input  logic ill_i,
  input  logic tf_i,
  input  logic sf_i,
  input  logic dbca_i,
  output logic busy_q,
  output logic srq_q,
  output logic merr_q,
  output logic tf_q,
  output logic sf_q,
  output logic dbca_q
);
  localparam int CNT_W = $clog2(SAMPLE_EDGE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_EDGE - 1);

  logic [CNT_W-1:0] cnt;
  logic             pend;

  initial assert (SAMPLE_EDGE >= 2) else $error("SAMPLE_EDGE must be at least 2");

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      pend <= 1'b0;
      {busy_q, srq_q, merr_q, tf_q, sf_q, dbca_q} <= '0;
    end else if (accept) begin
      cnt  <= '0;
      pend <= 1'b1;
      {busy_q, srq_q, merr_q, tf_q, sf_q, dbca_q} <= '0;
    end else if (cmd_done) begin
      pend <= 1'b0;
    end else if (pend) begin
      if (cnt == LAST) begin
        pend   <= 1'b0;
        busy_q <= busy_i;
        srq_q  <= srq_i;
        merr_q <= ill_i;
        tf_q   <= tf_i;
        sf_q   <= sf_i;
        dbca_q <= dbca_i;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_clear_on_accept_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!busy_q && !srq_q && !merr_q));
  assert_busy_only_from_pending_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(pend));
  assert_srq_only_from_pending_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(srq_q) |-> $past(pend));
endmodule

// File: rtl/rt_cmd_status.sv
module rt_cmd_status #(
  parameter int ADDR_W      = 5,
  parameter int SA_W        = 5,
  parameter int WC_W        = 5,
  parameter int SAMPLE_EDGE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  input  logic [4:0]        term_addr,
  input  logic              bcast_en,
  input  logic              cmd_done,
  input  logic              sub_busy,
  input  logic              sub_srq,
  input  logic              sub_illegal,
  input  logic              sub_tflag,
  input  logic              sub_sflag,
  input  logic              sub_dbca,
  output logic              addr_match,
  output logic [4:0]        cmd_sa,
  output logic              cmd_tx,
  output logic [4:0]        cmd_wc,
  output logic              in_cmd_n,
  output logic              mode_cmd,
  output logic [15:0]       status_word,
  output logic              xfer_inhibit
);
  import rtcs_pkg::*;
  localparam int ST_W = 16;

  logic accept, bcr_q, exempt_q;
  logic busy_q, srq_q, merr_q, tf_q, sf_q, dbca_q;
  logic [ADDR_W-1:0] addr_q;

  rtcs_decode #(.ADDR_W(ADDR_W), .SA_W(SA_W), .WC_W(WC_W)) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .term_addr(term_addr), .bcast_en(bcast_en), .cmd_done(cmd_done),
    .accept(accept), .addr_match(addr_match), .sa_q(cmd_sa), .tx_q(cmd_tx),
    .wc_q(cmd_wc), .in_cmd_n(in_cmd_n), .mode_q(mode_cmd), .bcr_q(bcr_q),
    .exempt_q(exempt_q), .addr_q(addr_q)
  );

  rtcs_sample #(.SAMPLE_EDGE(SAMPLE_EDGE)) u_smp (
    .clk(clk), .rst(rst), .accept(accept), .cmd_done(cmd_done),
    .busy_i(sub_busy), .srq_i(sub_srq), .ill_i(sub_illegal),
    .tf_i(sub_tflag), .sf_i(sub_sflag), .dbca_i(sub_dbca),
    .busy_q(busy_q), .srq_q(srq_q), .merr_q(merr_q),
    .tf_q(tf_q), .sf_q(sf_q), .dbca_q(dbca_q)
  );

  always_comb begin
    status_word = '0;
    status_word[ST_W-1 -: ADDR_W] = addr_q;
    status_word[ST_MERR] = merr_q;
    status_word[ST_SRQ]  = srq_q;
    status_word[ST_BCR]  = bcr_q;
    status_word[ST_BUSY] = busy_q;
    status_word[ST_SSF]  = sf_q;
    status_word[ST_DBCA] = dbca_q;
    status_word[ST_TF]   = tf_q;
    xfer_inhibit = busy_q && !in_cmd_n && !exempt_q;
  end

  assert_sync_data_exempt_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_cmd_n && mode_cmd && !cmd_tx && cmd_wc == MODE_SYNC_DATA) |-> !xfer_inhibit);
  assert_tx_vector_exempt_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_cmd_n && mode_cmd && cmd_tx && cmd_wc == MODE_TX_VECTOR) |-> !xfer_inhibit);
  assert_idle_no_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
    in_cmd_n |-> !xfer_inhibit);
endmodule

// File: tb/tb_rt_cmd_status.sv
module tb_rt_cmd_status;
  logic clk = 0, rst = 1;
  logic cmd_valid = 0, bcast_en = 0, cmd_done = 0;
  logic [15:0] cmd_word = '0;
  logic [4:0] term_addr = 5'd9;
  logic sub_busy = 0, sub_srq = 0, sub_illegal = 0, sub_tflag = 0, sub_sflag = 0, sub_dbca = 0;
  logic addr_match, cmd_tx, in_cmd_n, mode_cmd, xfer_inhibit;
  logic [4:0] cmd_sa, cmd_wc;
  logic [15:0] status_word;
  int checks = 0, errors = 0;
  localparam logic [15:0] A9 = 16'h4800;

  rt_cmd_status dut (.*);
  always #4 clk = ~clk;

  function automatic logic [15:0] mk(input logic [4:0] a, input logic t, input logic [4:0] s, input logic [4:0] w);
    return {a, t, s, w};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk); cmd_valid = 1; cmd_word = w;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic sample_in(input logic b, s, il, tf, sf, db);
    @(negedge clk); {sub_busy, sub_srq, sub_illegal, sub_tflag, sub_sflag, sub_dbca} = {b, s, il, tf, sf, db};
    @(negedge clk); {sub_busy, sub_srq, sub_illegal, sub_tflag, sub_sflag, sub_dbca} = '0;
  endtask

  task automatic done();
    @(negedge clk); cmd_done = 1;
    @(negedge clk); cmd_done = 0;
  endtask

  task automatic t_reset();
    chk("R10 in_cmd_n", in_cmd_n, 1); chk("R10 status", status_word, 0);
    chk("R10 inhibit", xfer_inhibit, 0); chk("R10 addr_match", addr_match, 0);
  endtask

  task automatic t_receive();
    send(mk(9, 0, 3, 2));
    chk("R1 match", addr_match, 1); chk("R3 in_cmd", in_cmd_n, 0);
    chk("R2 sa", cmd_sa, 3); chk("R2 wc", cmd_wc, 2); chk("R2 tx", cmd_tx, 0);
    chk("R4 not mode", mode_cmd, 0);
    sample_in(0, 0, 0, 0, 0, 0);
    chk("R9 status", status_word, A9); chk("R3 sa held", cmd_sa, 3);
    done(); chk("R3 released", in_cmd_n, 1);
  endtask

  task automatic t_other_addr();
    send(mk(4, 1, 5, 1));
    chk("R1 no match", addr_match, 0); chk("R1 in_cmd stays", in_cmd_n, 1);
    chk("R1 sa unchanged", cmd_sa, 3); chk("R1 status unchanged", status_word, A9);
  endtask

  task automatic t_broadcast();
    bcast_en = 0; send(mk(31, 0, 2, 4));
    chk("R1 bcast disabled", in_cmd_n, 1);
    bcast_en = 1; send(mk(31, 0, 2, 4));
    chk("R1 bcast enabled", in_cmd_n, 0);
    sample_in(0, 0, 0, 0, 0, 0);
    chk("R9 bcast bit", status_word, A9 | 16'h0010);
    done(); bcast_en = 0;
  endtask

  task automatic t_busy_edge();
    send(mk(9, 1, 7, 3));
    chk("R2 tx", cmd_tx, 1);
    sample_in(1, 0, 0, 0, 0, 0);
    chk("R5 busy captured", status_word, A9 | 16'h0008);
    chk("R6 inhibit", xfer_inhibit, 1);
    done(); chk("R6 inhibit off after done", xfer_inhibit, 0);
    send(mk(9, 1, 7, 3)); sub_busy = 1;          // high on first edge only
    @(negedge clk); sub_busy = 0;
    @(negedge clk); chk("R5 early busy ignored", status_word, A9);
    sub_busy = 1;                                // high after sample edge
    @(negedge clk); sub_busy = 0;
    chk("R5 late busy ignored", status_word, A9);
    chk("R6 no inhibit", xfer_inhibit, 0);
    done();
  endtask

  task automatic t_mode_exempt();
    send(mk(9, 0, 0, 5'b10001)); chk("R4 mode sa0", mode_cmd, 1);
    sample_in(1, 0, 0, 0, 0, 0);
    chk("R6 sync-data busy bit", status_word[3], 1); chk("R6 sync-data exempt", xfer_inhibit, 0);
    done();
    send(mk(9, 1, 31, 5'b10000)); chk("R4 mode sa31", mode_cmd, 1);
    sample_in(1, 0, 0, 0, 0, 0);
    chk("R6 tx-vector exempt", xfer_inhibit, 0);
    done();
    send(mk(9, 1, 0, 5'b10001));
    sample_in(1, 0, 0, 0, 0, 0);
    chk("R6 other mode inhibited", xfer_inhibit, 1);
    done();
  endtask

  task automatic t_srq_flags();
    send(mk(9, 0, 12, 8));
    sample_in(0, 1, 0, 0, 0, 0);
    chk("R7 srq bit only", status_word, A9 | 16'h0100); chk("R7 no inhibit", xfer_inhibit, 0);
    done();
    send(mk(9, 0, 12, 8));
    sample_in(0, 0, 1, 1, 1, 1);
    chk("R8 merr/tf/ssf/dbca", status_word, 16'h4C07);
    done();
  endtask

  task automatic t_cancel_restart();
    send(mk(9, 0, 4, 1));
    cmd_done = 1; @(negedge clk); cmd_done = 0; sub_busy = 1;
    @(negedge clk); sub_busy = 0;
    chk("R11 cancelled capture", status_word, A9); chk("R11 released", in_cmd_n, 1);
    send(mk(9, 0, 4, 1)); sub_busy = 1;
    send(mk(9, 1, 6, 2)); sub_busy = 0;          // second accept on first's sample edge
    chk("R11 restart fields", cmd_sa, 6); chk("R11 restart cleared", status_word, A9);
    sample_in(1, 0, 0, 0, 0, 0);
    chk("R11 restart sampled", status_word, A9 | 16'h0008);
    done();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_receive(); t_other_addr(); t_broadcast(); t_busy_edge();
    t_mode_exempt(); t_srq_flags(); t_cancel_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule